// File: doc/BRIEF.md
# Touch Key Group Resolver

This block turns a vector of raw per-key touch flags into the key-status vector that the rest of the chip reports. The keys are arranged as one group of eight or as two groups of four: a low group (keys 0..3) and a high group (keys 4..7). A two-bit grouping mode selects, for each group, one of two policies. Under single-key reporting the group shows at most one key. Under multi-key reporting the group shows every touched key.

When several keys in a single-key group are touched together, the key with the lowest index wins. This follows the scan order from key 0 toward key 7 and does not depend on how strongly a key is touched. The mode pins are captured once, on the first clock edge after reset is released. The captured mode then stays in force until the next reset.

The result is registered and changes only on the clock edge where the scan-complete strobe is high. A reader therefore never sees a partly resolved vector. The strobe is a plain qualifier with no back-pressure: the block accepts every strobe and has no ready output.

Top module: `kg_resolver`

## Requirements
- R1: While reset is asserted, and after it until the first strobe, `key_status` is 8'h00.
- R2: With mode 2'b11 (the default), all eight keys form one single-key group. On a strobe, `key_status` gets exactly the lowest-index set bit of `raw_touch`, or 0 if no bit is set.
- R3: With mode 2'b10, bits [3:0] and bits [7:4] each report only the lowest-index set bit inside that half.
- R4: With mode 2'b01, bits [3:0] report only their lowest-index set bit. Bits [7:4] copy `raw_touch[7:4]` unchanged.
- R5: With mode 2'b00, `key_status` copies all of `raw_touch`.
- R6: `key_status` loads only on a clock edge where `scan_done` is 1. On every other edge it holds its value, whatever `raw_touch` does.
- R7: `grp_mode` is captured on the first clock edge after reset release, and that edge already uses the captured value. Later changes to `grp_mode` have no effect until the next reset.
- R8: Any group with no touched key reports all zeros in its bits. No bit of `key_status` is ever set unless the matching `raw_touch` bit was set at the loading strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_mode | input | 2 | Grouping/reporting mode, captured after reset |
| scan_done | input | 1 | Scan-complete strobe; loads a new result |
| raw_touch | input | 8 | Raw per-key touch flags, bit n = key n |
| key_status | output | 8 | Registered resolved key vector, 1 = key on |

## Verification
Each result is due one clock edge after the strobe: the bench drives `raw_touch` and `scan_done` on the falling edge, the rising edge loads the register, and the bench compares on the next falling edge. The mode is captured on the first rising edge after reset is released. The bench therefore sets the mode before that release and changes it only once at least one edge has passed. To check the hold rule, the bench changes `raw_touch` with the strobe low and samples one edge later, expecting no change. All 256 touch patterns are swept in all four modes, against expected values computed arithmetically from the lowest set bit of each group.

// File: rtl/kg_pkg.sv
package kg_pkg;
  typedef enum logic [1:0] {
    MODE_MULTI_ALL   = 2'b00,
    MODE_LO_SGL_HI_M = 2'b01,
    MODE_SPLIT_SGL   = 2'b10,
    MODE_SGL_ALL     = 2'b11
  } grp_mode_e;
endpackage

// File: rtl/kg_mode_latch.sv
module kg_mode_latch
  import kg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] mode_in,
  output grp_mode_e mode_eff,
  output logic      loaded
);
  grp_mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SGL_ALL;
      loaded <= 1'b0;
    end else if (!loaded) begin
      mode_q <= grp_mode_e'(mode_in);
      loaded <= 1'b1;
    end
  end

  // The capture edge itself already uses the pins.
  assign mode_eff = loaded ? mode_q : grp_mode_e'(mode_in);
endmodule

// File: rtl/kg_first_pick.sv
module kg_first_pick #(
  parameter int W = 4
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] grant
);
  logic [W-1:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_chain
    assign grant[i] = req[i] & ~seen[i];
    if (i < W - 1) begin : g_next
      assign seen[i+1] = seen[i] | req[i];
    end
  end
endmodule

// File: rtl/kg_resolver.sv
module kg_resolver
  import kg_pkg::*;
#(
  parameter int KEYS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      grp_mode,
  input  logic            scan_done,
  input  logic [KEYS-1:0] raw_touch,
  output logic [KEYS-1:0] key_status
);
  localparam int HALF = KEYS / 2;

  grp_mode_e       mode_eff;
  logic            mode_loaded;
  logic [KEYS-1:0] pick_all;
  logic [HALF-1:0] pick_lo;
  logic [HALF-1:0] pick_hi;
  logic [KEYS-1:0] resolved;

  kg_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_in  (grp_mode),
    .mode_eff (mode_eff),
    .loaded   (mode_loaded)
  );

  kg_first_pick #(.W(KEYS)) u_pick_all (.req(raw_touch), .grant(pick_all));
  kg_first_pick #(.W(HALF)) u_pick_lo  (.req(raw_touch[HALF-1:0]), .grant(pick_lo));
  kg_first_pick #(.W(HALF)) u_pick_hi  (.req(raw_touch[KEYS-1:HALF]), .grant(pick_hi));

  always_comb begin
    unique case (mode_eff)
      MODE_SGL_ALL:     resolved = pick_all;
      MODE_SPLIT_SGL:   resolved = {pick_hi, pick_lo};
      MODE_LO_SGL_HI_M: resolved = {raw_touch[KEYS-1:HALF], pick_lo};
      default:          resolved = raw_touch;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         key_status <= '0;
    else if (scan_done) key_status <= resolved;
  end
endmodule

// File: rtl/kg_resolver_chk.sv
module kg_resolver_chk
  import kg_pkg::*;
#(
  parameter int KEYS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scan_done,
  input logic [KEYS-1:0] raw_touch,
  input logic [KEYS-1:0] key_status,
  input grp_mode_e       mode_eff,
  input logic            mode_loaded
);
  localparam int HALF = KEYS / 2;

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (key_status == '0 || !rst_n));

  a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done |=> $stable(key_status));

  a_r8_subset_of_raw: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> ((key_status & ~$past(raw_touch)) == '0));

  a_r2_single_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && mode_eff == MODE_SGL_ALL) |=> $onehot0(key_status));

  a_r3_split_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && mode_eff == MODE_SPLIT_SGL) |=>
      ($onehot0(key_status[HALF-1:0]) && $onehot0(key_status[KEYS-1:HALF])));

  a_r4_high_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && mode_eff == MODE_LO_SGL_HI_M) |=>
      (key_status[KEYS-1:HALF] == $past(raw_touch[KEYS-1:HALF])));

  a_r5_multi_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && mode_eff == MODE_MULTI_ALL) |=> (key_status == $past(raw_touch)));

  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_loaded && $past(mode_loaded)) |-> $stable(mode_eff));

  a_r8_touch_gives_key: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && raw_touch != '0) |=> (key_status != '0));
endmodule

bind kg_resolver kg_resolver_chk #(.KEYS(KEYS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scan_done   (scan_done),
  .raw_touch   (raw_touch),
  .key_status  (key_status),
  .mode_eff    (mode_eff),
  .mode_loaded (mode_loaded)
);

// File: tb/kg_resolver_tb.sv
module kg_resolver_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] grp_mode = 2'b11;
  logic       scan_done = 1'b0;
  logic [7:0] raw_touch = '0;
  logic [7:0] key_status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  kg_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .grp_mode(grp_mode),
    .scan_done(scan_done), .raw_touch(raw_touch), .key_status(key_status)
  );

  function automatic logic [7:0] lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 8'(1 << i);
    return 8'h00;
  endfunction

  function automatic logic [7:0] expect_for(input logic [1:0] m, input logic [7:0] r);
    logic [7:0] lo, hi;
    lo = lowest({4'h0, r[3:0]});
    hi = lowest({4'h0, r[7:4]}) << 4;
    case (m)
      2'b11:   return lowest(r);
      2'b10:   return lo | hi;
      2'b01:   return lo | {r[7:4], 4'h0};
      default: return r;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    grp_mode = m;
    scan_done = 1'b0;
    raw_touch = 8'hFF;
    @(negedge clk);
    check("R1", key_status, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", key_status, 8'h00);
  endtask

  task automatic strobe(input logic [7:0] r);
    raw_touch = r;
    scan_done = 1'b1;
    @(negedge clk);
    scan_done = 1'b0;
  endtask

  initial begin
    // R2..R5 and R8: full sweep of 256 patterns in every mode.
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      for (int r = 0; r < 256; r++) begin
        strobe(8'(r));
        check(m == 3 ? "R2" : m == 2 ? "R3" : m == 1 ? "R4" : "R5",
              key_status, expect_for(2'(m), 8'(r)));
        if (r[3:0] == 0) check("R8", key_status & 8'h0F, 8'h00);
        if (r[7:4] == 0) check("R8", key_status & 8'hF0, 8'h00);
      end
    end

    // R6: raw changes without a strobe leave the output unchanged.
    do_reset(2'b00);
    strobe(8'hA5);
    check("R6", key_status, 8'hA5);
    raw_touch = 8'h3C;
    @(negedge clk);
    check("R6", key_status, 8'hA5);
    raw_touch = 8'h00;
    @(negedge clk);
    @(negedge clk);
    check("R6", key_status, 8'hA5);

    // R7: a mode change after capture has no effect until the next reset.
    do_reset(2'b11);
    grp_mode = 2'b00;
    strobe(8'hF6);
    check("R7", key_status, 8'h02);
    grp_mode = 2'b10;
    strobe(8'hC8);
    check("R7", key_status, 8'h08);
    do_reset(2'b00);
    strobe(8'hC8);
    check("R7", key_status, 8'hC8);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule